// File: doc/BRIEF.md
# Wormhole Router Input Port

This block is the receive side of one port of a mesh network-on-chip router. An upstream sender presents 8-bit flits on a valid/acknowledge handshake. Each flit carries start-of-packet and end-of-packet markers. Accepted flits go into a four-entry FIFO, which is the only storage in the router's data path. The acknowledge is given only while the FIFO has a free slot, so the FIFO never overflows.

Every packet begins with one header flit, and that header carries the destination coordinates. When the header reaches the FIFO head, the block works out the output direction with dimension-ordered routing: it corrects X first, then Y, and ejects locally on arrival. It registers that direction as a one-hot request to the crossbar arbiter. The request is held unchanged while the whole packet streams out. Flits leave only in cycles where the arbiter's grant and the downstream ready are both high. The request drops after the end-of-packet flit has been read.

Top module: `wh_rx_port`

## Requirements
- R1: After reset, `xb_req` is all zeros and `xb_vld` is low.
- R2: `up_ack` is high in a cycle exactly when `up_vld` is high and fewer than 4 flits are stored. A flit is taken on each rising edge where `up_vld` and `up_ack` are both high.
- R3: The FIFO holds at most 4 flits. With 4 flits stored, an offered flit is not acknowledged and is not stored.
- R4: Flits leave on `xb_flit`/`xb_sop`/`xb_eop` in arrival order, with their markers unchanged.
- R5: The header's destination X is `flit[1:0]` and its destination Y is `flit[3:2]`. Bits [7:4] are ignored. If X is greater than the router's own X, the request is East (`xb_req` bit 1). If X is smaller, the request is West (bit 3).
- R6: If X equals the router's own X, a larger Y requests North (bit 0) and a smaller Y requests South (bit 2).
- R7: If both coordinates equal the router's own, the request is the local ejection output (bit 4).
- R8: The request is registered one clock after a start-of-packet flit is at the FIFO head. It has exactly one bit set and stays unchanged until the end-of-packet flit is read out. `xb_vld` is high only while a request is held and the FIFO is not empty.
- R9: The request clears on the edge that reads the end-of-packet flit. A following packet's header then registers its own request one clock later.
- R10: A flit is removed from the FIFO only on an edge where `xb_gnt` and `xb_rdy` are both high. Either signal alone leaves the head flit in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_vld | input | 1 | Upstream flit valid |
| up_flit | input | 8 | Upstream flit data |
| up_sop | input | 1 | Upstream start-of-packet marker |
| up_eop | input | 1 | Upstream end-of-packet marker |
| up_ack | output | 1 | Flit accepted this cycle |
| xb_req | output | 5 | One-hot output request: North, East, South, West, Local (bits 0 to 4) |
| xb_gnt | input | 1 | Grant from the output arbiter |
| xb_rdy | input | 1 | Downstream ready |
| xb_vld | output | 1 | Head flit presented to the crossbar |
| xb_flit | output | 8 | Head flit data |
| xb_sop | output | 1 | Head flit start-of-packet marker |
| xb_eop | output | 1 | Head flit end-of-packet marker |

## Verification
On every cycle, the embedded assertions check five properties:
- the FIFO neither overflows nor underflows;
- the request is zero or one-hot;
- a request latched from a header has exactly one bit set;
- the request stays stable while a packet is in flight;
- the request clears right after an end-of-packet read.

The bench scenarios are needed to show that the chosen direction is correct for each destination, and that data order and markers survive the FIFO. They also show that a full FIFO refuses a fifth flit, and that a grant without ready (or ready without grant) leaves the head in place. Finally, they show the one-cycle gap and the new request between back-to-back packets.

// File: rtl/wh_rx_pkg.sv
package wh_rx_pkg;

  localparam int unsigned NUM_DIR = 5;

  // Bit positions of the one-hot output request
  localparam int unsigned DIR_N = 0;
  localparam int unsigned DIR_E = 1;
  localparam int unsigned DIR_S = 2;
  localparam int unsigned DIR_W = 3;
  localparam int unsigned DIR_L = 4;

  typedef logic [NUM_DIR-1:0] dir_vec_t;

  // Dimension-ordered route: resolve X, then Y, then eject locally
  function automatic dir_vec_t xy_route(input int unsigned dst_x, input int unsigned dst_y,
                                        input int unsigned own_x, input int unsigned own_y);
    dir_vec_t r;
    r = '0;
    if (dst_x > own_x)      r[DIR_E] = 1'b1;
    else if (dst_x < own_x) r[DIR_W] = 1'b1;
    else if (dst_y > own_y) r[DIR_N] = 1'b1;
    else if (dst_y < own_y) r[DIR_S] = 1'b1;
    else                    r[DIR_L] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/wh_rx_fifo.sv
module wh_rx_fifo #(
  parameter int unsigned WIDTH = 10,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] count;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < CNT_W'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count != '0)); // R10

endmodule

// File: rtl/wh_rx_route.sv
module wh_rx_route
  import wh_rx_pkg::*;
#(
  parameter int unsigned COORD_W = 2,
  parameter int unsigned MY_X    = 1,
  parameter int unsigned MY_Y    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 head_vld,
  input  logic                 head_sop,
  input  logic [2*COORD_W-1:0] head_dst,
  input  logic                 rd_eop,
  output logic                 active,
  output dir_vec_t             req
);
  logic [COORD_W-1:0] dst_x, dst_y;
  logic               latch_ev;

  assign dst_x    = head_dst[COORD_W-1:0];
  assign dst_y    = head_dst[2*COORD_W-1:COORD_W];
  assign latch_ev = !active && head_vld && head_sop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      req    <= '0;
    end else if (latch_ev) begin
      active <= 1'b1;
      req    <= xy_route(32'(dst_x), 32'(dst_y), MY_X, MY_Y);
    end else if (active && rd_eop) begin
      active <= 1'b0;
      req    <= '0;
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req)); // R8
  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ev |=> ($countones(req) == 1)); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rd_eop) |=> $stable(req)); // R8
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_eop) |=> (req == '0)); // R9

endmodule

// File: rtl/wh_rx_port.sv
module wh_rx_port
  import wh_rx_pkg::*;
#(
  parameter int unsigned FLIT_W  = 8,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned COORD_W = 2,
  parameter int unsigned MY_X    = 1,
  parameter int unsigned MY_Y    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_vld,
  input  logic [FLIT_W-1:0] up_flit,
  input  logic              up_sop,
  input  logic              up_eop,
  output logic              up_ack,
  output logic [4:0]        xb_req,
  input  logic              xb_gnt,
  input  logic              xb_rdy,
  output logic              xb_vld,
  output logic [FLIT_W-1:0] xb_flit,
  output logic              xb_sop,
  output logic              xb_eop
);
  localparam int unsigned ENT_W = FLIT_W + 2;

  logic             fifo_full, fifo_empty, wr_en, rd_en, rd_eop, active;
  logic [ENT_W-1:0] head;
  dir_vec_t         req;

  // Flow control: acknowledge only into a free slot
  assign up_ack = up_vld && !fifo_full;
  assign wr_en  = up_ack;

  wh_rx_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data ({up_sop, up_eop, up_flit}),
    .rd_en   (rd_en),
    .head    (head),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  assign xb_sop  = head[ENT_W-1];
  assign xb_eop  = head[ENT_W-2];
  assign xb_flit = head[FLIT_W-1:0];
  assign xb_vld  = active && !fifo_empty;
  assign rd_en   = xb_vld && xb_gnt && xb_rdy;
  assign rd_eop  = rd_en && xb_eop;

  wh_rx_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .head_vld (!fifo_empty),
    .head_sop (xb_sop),
    .head_dst (head[2*COORD_W-1:0]),
    .rd_eop   (rd_eop),
    .active   (active),
    .req      (req)
  );

  assign xb_req = req;

  AST_VLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xb_vld |-> (xb_req != '0)); // R8

endmodule

// File: tb/wh_rx_port_tb.sv
module wh_rx_port_tb;
  localparam int MX = 1;
  localparam int MY = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_vld = 1'b0, up_sop = 1'b0, up_eop = 1'b0;
  logic [7:0] up_flit = '0;
  logic       up_ack;
  logic [4:0] xb_req;
  logic       xb_gnt = 1'b0, xb_rdy = 1'b0;
  logic       xb_vld, xb_sop, xb_eop;
  logic [7:0] xb_flit;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  wh_rx_port #(.MY_X(MX), .MY_Y(MY)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_vld(up_vld), .up_flit(up_flit),
    .up_sop(up_sop), .up_eop(up_eop), .up_ack(up_ack), .xb_req(xb_req),
    .xb_gnt(xb_gnt), .xb_rdy(xb_rdy), .xb_vld(xb_vld), .xb_flit(xb_flit),
    .xb_sop(xb_sop), .xb_eop(xb_eop)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // Expected direction, worked out from the requirement text
  function automatic logic [4:0] exp_dir(input logic [7:0] hdr);
    int dx, dy;
    dx = int'(hdr[1:0]);
    dy = int'(hdr[3:2]);
    if (dx == MX && dy == MY) return 5'b10000;   // R7 local
    if (dx != MX) return (dx < MX) ? 5'b01000 : 5'b00010; // R5
    return (dy < MY) ? 5'b00100 : 5'b00001;      // R6
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] f, input logic s, input logic e);
    @(negedge clk);
    up_vld = 1'b1; up_flit = f; up_sop = s; up_eop = e;
    #1;
    while (!up_ack) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    up_vld = 1'b0; up_sop = 1'b0; up_eop = 1'b0;
  endtask

  task automatic pop(input string tag, input logic [7:0] f, input logic s, input logic e,
                     input logic [4:0] dir);
    @(negedge clk);
    xb_gnt = 1'b1; xb_rdy = 1'b1;
    #1;
    check({tag, " vld"}, 16'(xb_vld), 16'd1);
    check({tag, " flit"}, {6'd0, xb_sop, xb_eop, xb_flit}, {6'd0, s, e, f});
    check({tag, " req held R8"}, 16'(xb_req), 16'(dir));
    @(posedge clk); #1;
    xb_gnt = 1'b0; xb_rdy = 1'b0;
  endtask

  task automatic t_route(input string tag, input logic [7:0] hdr, input logic [7:0] pay);
    logic [4:0] d;
    d = exp_dir(hdr);
    send(hdr, 1'b1, 1'b0);
    send(pay, 1'b0, 1'b1);
    @(negedge clk); #1;
    check({tag, " dir"}, 16'(xb_req), 16'(d));
    pop({tag, " hdr R4"}, hdr, 1'b1, 1'b0, d);
    pop({tag, " pay R4"}, pay, 1'b0, 1'b1, d);
    @(negedge clk); #1;
    check({tag, " release R9"}, 16'(xb_req), 16'd0);
    check({tag, " idle vld R9"}, 16'(xb_vld), 16'd0);
  endtask

  task automatic t_reset();
    #1;
    check("R1 req", 16'(xb_req), 16'd0);
    check("R1 vld", 16'(xb_vld), 16'd0);
  endtask

  task automatic t_full();
    logic [4:0] d;
    d = exp_dir(8'h03);
    send(8'h03, 1'b1, 1'b0);
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b0);
    send(8'h33, 1'b0, 1'b1);
    @(negedge clk);
    up_vld = 1'b1; up_flit = 8'h44; up_sop = 1'b1; up_eop = 1'b1;
    #1;
    check("R3 full no ack", 16'(up_ack), 16'd0);
    @(posedge clk); @(negedge clk); #1;
    check("R3 still no ack", 16'(up_ack), 16'd0);
    up_vld = 1'b0; up_sop = 1'b0; up_eop = 1'b0;
    #1;
    check("R2 no vld no ack", 16'(up_ack), 16'd0);
    pop("R4 full 0", 8'h03, 1'b1, 1'b0, d);
    @(negedge clk);
    up_vld = 1'b1; #1;
    check("R2 ack with space", 16'(up_ack), 16'd1);
    up_vld = 1'b0;
    pop("R4 full 1", 8'h11, 1'b0, 1'b0, d);
    pop("R4 full 2", 8'h22, 1'b0, 1'b0, d);
    pop("R4 full 3", 8'h33, 1'b0, 1'b1, d);
    @(negedge clk); #1;
    check("R3 refused flit not stored", 16'(xb_vld), 16'd0);
    repeat (2) @(negedge clk); #1;
    check("R3 still empty", 16'(xb_vld), 16'd0);
  endtask

  task automatic t_gate();
    logic [4:0] d;
    d = exp_dir(8'hF1);
    send(8'hF1, 1'b1, 1'b0);
    send(8'h5A, 1'b0, 1'b1);
    @(negedge clk); xb_gnt = 1'b1; xb_rdy = 1'b0;
    @(negedge clk); xb_gnt = 1'b0; xb_rdy = 1'b1;
    @(negedge clk); xb_rdy = 1'b0; #1;
    check("R10 head kept", {6'd0, xb_sop, xb_eop, xb_flit}, {6'd0, 1'b1, 1'b0, 8'hF1});
    pop("R10 hdr", 8'hF1, 1'b1, 1'b0, d);
    pop("R10 pay", 8'h5A, 1'b0, 1'b1, d);
  endtask

  task automatic t_b2b();
    logic [4:0] da, db;
    da = exp_dir(8'h03);
    db = exp_dir(8'h0D);
    send(8'h03, 1'b1, 1'b0);
    send(8'h77, 1'b0, 1'b1);
    send(8'h0D, 1'b1, 1'b1);
    pop("R9 pkt A hdr", 8'h03, 1'b1, 1'b0, da);
    pop("R9 pkt A eop", 8'h77, 1'b0, 1'b1, da);
    @(negedge clk); #1;
    check("R9 gap between packets", 16'(xb_req), 16'd0);
    pop("R9 pkt B single", 8'h0D, 1'b1, 1'b1, db);
    @(negedge clk); #1;
    check("R9 pkt B released", 16'(xb_req), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_route("R5 east", 8'hA3, 8'h01);
    t_route("R5 west", 8'h5C, 8'h02);
    t_route("R6 north", 8'h0D, 8'h03);
    t_route("R6 south", 8'hC1, 8'h04);
    t_route("R7 local", 8'h69, 8'h05);
    t_full();
    t_gate();
    t_b2b();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule